// File: doc/BRIEF.md
# Ping-Pong Circular DMA Channel

This block is one peripheral-to-memory DMA channel that runs without end over two equal halves of a shared SRAM buffer. Software loads two base addresses and an item count, then enables the channel. Every peripheral request moves one data item into the half that is currently active. The write address steps forward by the item size on each beat. When the programmed number of items has been written, the channel changes to the other half, starts again at that half's base, reloads its counter and keeps running. A second engine can drain the finished half while this channel fills the other one.

Each wrap raises a one-cycle completion pulse, which can trigger that second engine, and sets a sticky completion flag. Any bus master clears the flag by writing a mask to the clear register. If a wrap happens while the flag is still set, the channel also sets an overrun flag. The channel stops only when it is disabled through the control register.

Top module: `dbuf_dma_chan`

## Requirements
- R1: After reset, the outputs perAck, memWrEn, tcPulse, doneFlag, overrunFlag, activeBuf and chanEnabled are all 0.
- R2: The register selects are 0 = base of half 0, 1 = base of half 1, 2 = item count, 3 = control (bit 0 enable), 4 = flag clear. Writing control bit 0 = 1 to a disabled channel starts it on half 0 (activeBuf = 0), at that half's base, with the counter loaded from the count register.
- R3: When the channel is enabled and perReq is high with perAck low, the channel accepts one beat. In the next cycle memWrEn and perAck are 1 for exactly one cycle, memWrData equals the perData that was sampled, and memAddr equals the active base plus ITEM_BYTES times the number of beats already taken in this half.
- R4: The beat that empties the counter is written to the old half. The channel then toggles activeBuf, restarts the address at the new half's base and reloads the counter. It keeps running across any number of wraps.
- R5: Every wrap drives tcPulse high for exactly one cycle, in the same cycle as that beat's memWrEn, and sets doneFlag.
- R6: A flag-clear write with bit 0 set clears doneFlag, and one with bit 1 set clears overrunFlag. A wrap in the same cycle takes priority over the clear.
- R7: A wrap while doneFlag is already set sets overrunFlag, which stays set until it is cleared. tcPulse is still produced.
- R8: Writes to the base or count registers are ignored while the channel is enabled.
- R9: Writing control bit 0 = 0 disables the channel (chanEnabled = 0). No memory write or ack then occurs, even with perReq held high.
- R10: If the count register holds 0 when the channel is enabled, the channel performs no transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 3 | Register select |
| regWrData | input | ADDR_W | Register write data |
| perReq | input | 1 | Peripheral request |
| perData | input | DATA_W | Peripheral data item |
| perAck | output | 1 | Beat accepted, one cycle |
| memWrEn | output | 1 | Memory write strobe |
| memAddr | output | ADDR_W | Memory write address |
| memWrData | output | DATA_W | Memory write data |
| tcPulse | output | 1 | Wrap pulse to an external engine |
| doneFlag | output | 1 | Sticky completion flag |
| overrunFlag | output | 1 | Sticky overrun flag |
| activeBuf | output | 1 | Half currently being filled |
| chanEnabled | output | 1 | Channel running |

## Verification
The main function is driven with a stream of eight beats against a count of three, so the stream crosses two wraps and returns to half 0. This separates a correct address step from one that misses the restart after a swap or selects the wrong base. A second pass re-enables the channel after base and count writes made while it was running, which shows whether those writes leaked into the configuration and whether a new start goes back to half 0. Wraps with the flag set and with the flag cleared tell the overrun rule apart from a flag that simply copies the pulse. A held request while disabled, and an enable with a zero count, show that no beat starts in those cases.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;

  typedef enum logic [2:0] {
    SEL_BASE0 = 3'd0,
    SEL_BASE1 = 3'd1,
    SEL_COUNT = 3'd2,
    SEL_CTRL  = 3'd3,
    SEL_CLEAR = 3'd4
  } regSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic start;  // channel just enabled
    logic beat;   // one item accepted this cycle
    logic wrap;   // this beat empties the counter
  } dpStrobe_t;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CLR_DONE_BIT  = 0;
  localparam int CLR_OVRN_BIT  = 1;

endpackage

// File: rtl/dbuf_ctrl.sv
module dbuf_ctrl
  import dbuf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [2:0]       regSel,
  input  logic [CNT_W-1:0] regWrData,
  input  logic             perReq,
  output dpStrobe_t        strb,
  output logic             perAck,
  output logic             tcPulse,
  output logic             doneFlag,
  output logic             overrunFlag,
  output logic             chanEnabled
);

  logic [CNT_W-1:0] countReg;
  logic [CNT_W-1:0] remain;
  logic             ctrlWr;
  logic             clrWr;
  logic             cfgWr;

  always_comb begin
    ctrlWr     = regWrEn && (regSel == SEL_CTRL);
    clrWr      = regWrEn && (regSel == SEL_CLEAR);
    cfgWr      = regWrEn && (regSel == SEL_COUNT) && !chanEnabled;
    strb.start = ctrlWr && regWrData[CTRL_EN_BIT] && !chanEnabled;
    strb.beat  = chanEnabled && perReq && !perAck && (remain != '0);
    strb.wrap  = strb.beat && (remain == CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanEnabled <= 1'b0;
      countReg    <= '0;
      remain      <= '0;
      perAck      <= 1'b0;
      tcPulse     <= 1'b0;
      doneFlag    <= 1'b0;
      overrunFlag <= 1'b0;
    end else begin
      if (ctrlWr) chanEnabled <= regWrData[CTRL_EN_BIT];
      if (cfgWr) countReg <= regWrData;

      if (strb.start || strb.wrap) remain <= countReg;
      else if (strb.beat)          remain <= remain - CNT_W'(1);

      perAck  <= strb.beat;
      tcPulse <= strb.wrap;

      if (strb.wrap)                            doneFlag <= 1'b1;
      else if (clrWr && regWrData[CLR_DONE_BIT]) doneFlag <= 1'b0;

      if (strb.wrap && doneFlag)                overrunFlag <= 1'b1;
      else if (clrWr && regWrData[CLR_OVRN_BIT]) overrunFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/dbuf_datapath.sv
module dbuf_datapath
  import dbuf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int ITEM_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regSel,
  input  logic [ADDR_W-1:0] regWrData,
  input  logic              chanEnabled,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] perData,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              activeBuf
);

  localparam int NUM_BUF = 2;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(ITEM_BYTES);

  logic [ADDR_W-1:0] baseReg [NUM_BUF];
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] curAddr;

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_base
    always_ff @(posedge clk) begin
      if (!rstN) baseReg[b] <= '0;
      else if (regWrEn && !chanEnabled && (regSel == 3'(b))) baseReg[b] <= regWrData;
    end
  end

  assign curAddr = baseReg[activeBuf] + offset;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memWrEn   <= 1'b0;
      memAddr   <= '0;
      memWrData <= '0;
      activeBuf <= 1'b0;
      offset    <= '0;
    end else begin
      memWrEn <= strb.beat;
      if (strb.beat) begin
        memAddr   <= curAddr;
        memWrData <= perData;
      end
      if (strb.start)     activeBuf <= 1'b0;
      else if (strb.wrap) activeBuf <= ~activeBuf;
      if (strb.start || strb.wrap) offset <= '0;
      else if (strb.beat)          offset <= offset + STEP;
    end
  end

endmodule

// File: rtl/dbuf_dma_chan.sv
module dbuf_dma_chan
  import dbuf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 16,
  parameter int ITEM_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regSel,
  input  logic [ADDR_W-1:0] regWrData,
  input  logic              perReq,
  input  logic [DATA_W-1:0] perData,
  output logic              perAck,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              tcPulse,
  output logic              doneFlag,
  output logic              overrunFlag,
  output logic              activeBuf,
  output logic              chanEnabled
);

  dpStrobe_t strb;

  dbuf_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regSel      (regSel),
    .regWrData   (regWrData[CNT_W-1:0]),
    .perReq      (perReq),
    .strb        (strb),
    .perAck      (perAck),
    .tcPulse     (tcPulse),
    .doneFlag    (doneFlag),
    .overrunFlag (overrunFlag),
    .chanEnabled (chanEnabled)
  );

  dbuf_datapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .ITEM_BYTES (ITEM_BYTES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regSel      (regSel),
    .regWrData   (regWrData),
    .chanEnabled (chanEnabled),
    .strb        (strb),
    .perData     (perData),
    .memWrEn     (memWrEn),
    .memAddr     (memAddr),
    .memWrData   (memWrData),
    .activeBuf   (activeBuf)
  );

endmodule

// File: rtl/dbuf_dma_chk.sv
module dbuf_dma_chk (
  input logic clk,
  input logic rstN,
  input logic perAck,
  input logic memWrEn,
  input logic tcPulse,
  input logic doneFlag,
  input logic overrunFlag,
  input logic activeBuf,
  input logic chanEnabled
);

  // R3: each memory write comes with its ack
  assert_wr_acked_R3: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> perAck);

  // R3: ack lasts one cycle
  assert_ack_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    perAck |=> !perAck);

  // R4: a wrap comes with a half swap
  assert_swap_on_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    tcPulse |-> (activeBuf != $past(activeBuf)));

  // R5: the pulse rides on a write and sets the flag
  assert_pulse_on_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    tcPulse |-> (memWrEn && doneFlag));

  // R7: a wrap with the flag set raises overrun
  assert_overrun_R7: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && chanEnabled) |=> (tcPulse ? overrunFlag : 1'b1));

  // R9: no writes after a disabled cycle
  assert_idle_when_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    !chanEnabled |=> !memWrEn);

endmodule

bind dbuf_dma_chan dbuf_dma_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .perAck      (perAck),
  .memWrEn     (memWrEn),
  .tcPulse     (tcPulse),
  .doneFlag    (doneFlag),
  .overrunFlag (overrunFlag),
  .activeBuf   (activeBuf),
  .chanEnabled (chanEnabled)
);

// File: tb/sim_dbuf_dma_chan.sv
module sim_dbuf_dma_chan;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regSel = '0;
  logic [31:0] regWrData = '0;
  logic        perReq = 1'b0;
  logic [31:0] perData = '0;
  logic        perAck, memWrEn, tcPulse, doneFlag, overrunFlag, activeBuf, chanEnabled;
  logic [31:0] memAddr, memWrData;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  dbuf_dma_chan u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .perReq(perReq), .perData(perData), .perAck(perAck), .memWrEn(memWrEn),
    .memAddr(memAddr), .memWrData(memWrData), .tcPulse(tcPulse), .doneFlag(doneFlag),
    .overrunFlag(overrunFlag), .activeBuf(activeBuf), .chanEnabled(chanEnabled)
  );

  // {expected address, expected tcPulse, expected activeBuf after the beat}
  localparam logic [33:0] VEC [8] = '{
    {32'h0000_1000, 1'b0, 1'b0},
    {32'h0000_1004, 1'b0, 1'b0},
    {32'h0000_1008, 1'b1, 1'b1},
    {32'h0000_2000, 1'b0, 1'b1},
    {32'h0000_2004, 1'b0, 1'b1},
    {32'h0000_2008, 1'b1, 1'b0},
    {32'h0000_1000, 1'b0, 1'b0},
    {32'h0000_1004, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] sel, input logic [31:0] val);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic doBeat(input logic [31:0] data, input logic [31:0] expAddr,
                        input logic expTc, input logic expBuf);
    @(negedge clk);
    perReq = 1'b1; perData = data;
    @(negedge clk);
    perReq = 1'b0;
    chk("R3 memWrEn", 32'(memWrEn), 32'd1);
    chk("R3 perAck", 32'(perAck), 32'd1);
    chk("R3 memWrData", memWrData, data);
    chk("R3/R4 memAddr", memAddr, expAddr);
    chk("R5 tcPulse", 32'(tcPulse), 32'(expTc));
    chk("R4 activeBuf", 32'(activeBuf), 32'(expBuf));
    @(negedge clk);
    chk("R5 tcPulse one cycle", 32'(tcPulse), 32'd0);
    chk("R3 ack one cycle", 32'(perAck), 32'd0);
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 perAck", 32'(perAck), 0);
    chk("R1 memWrEn", 32'(memWrEn), 0);
    chk("R1 tcPulse", 32'(tcPulse), 0);
    chk("R1 doneFlag", 32'(doneFlag), 0);
    chk("R1 overrunFlag", 32'(overrunFlag), 0);
    chk("R1 activeBuf", 32'(activeBuf), 0);
    chk("R1 chanEnabled", 32'(chanEnabled), 0);

    regWrite(3'd0, 32'h1000);
    regWrite(3'd1, 32'h2000);
    regWrite(3'd2, 32'd3);
    regWrite(3'd3, 32'd1);
    chk("R2 chanEnabled", 32'(chanEnabled), 1);
    chk("R2 activeBuf", 32'(activeBuf), 0);

    // R3 R4 R5 table walk across two wraps
    for (int i = 0; i < 8; i++)
      doBeat(32'hA000_0000 + 32'(i), VEC[i][33:2], VEC[i][1], VEC[i][0]);

    chk("R5 doneFlag", 32'(doneFlag), 1);
    chk("R7 overrunFlag", 32'(overrunFlag), 1);
    regWrite(3'd4, 32'd1);
    chk("R6 doneFlag cleared", 32'(doneFlag), 0);
    chk("R6 overrun kept", 32'(overrunFlag), 1);
    regWrite(3'd4, 32'd2);
    chk("R6 overrun cleared", 32'(overrunFlag), 0);

    // R8: config writes while enabled
    regWrite(3'd0, 32'h5000);
    regWrite(3'd2, 32'd1);
    // R9: disable and hold request
    regWrite(3'd3, 32'd0);
    chk("R9 chanEnabled", 32'(chanEnabled), 0);
    @(negedge clk);
    perReq = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R9 no write when off", 32'(memWrEn), 0);
      chk("R9 no ack when off", 32'(perAck), 0);
    end
    perReq = 1'b0;

    regWrite(3'd3, 32'd1);
    // R2 restart at half 0; R8 base and count unchanged
    doBeat(32'hB000_0000, 32'h1000, 1'b0, 1'b0);
    doBeat(32'hB000_0001, 32'h1004, 1'b0, 1'b0);
    doBeat(32'hB000_0002, 32'h1008, 1'b1, 1'b1);
    chk("R5 doneFlag set", 32'(doneFlag), 1);
    chk("R7 no overrun with clear flag", 32'(overrunFlag), 0);

    // R10: zero count
    regWrite(3'd3, 32'd0);
    regWrite(3'd2, 32'd0);
    regWrite(3'd3, 32'd1);
    @(negedge clk);
    perReq = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 no write at zero count", 32'(memWrEn), 0);
    end
    perReq = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule